// File: doc/BRIEF.md
# Reloadable Down-Counting Interrupt Timer

This block is a 32-bit countdown timer that software drives through five word-addressed registers. Software places a start value in a load register and a match value in a compare register, then sets the run bit. The counter falls by one on each prescaled tick. When it passes zero it either takes the load value again or wraps to all ones, depending on a control bit. Each time a step lands the counter on the compare value, a sticky match flag is set. That flag, gated by an enable bit, drives a level interrupt until software writes one to clear it.

Register accesses arrive on a valid/ready request channel. A read answers on a response channel that is also valid/ready. The block accepts a request in any cycle where `req_valid` and `req_ready` are both high. A read's data appears with `rsp_valid` on the next clock. If the host holds `rsp_ready` low, the response stays frozen and `req_ready` falls, so no further request is taken until the response is consumed. Writes produce no response. A self-clearing soft reset bit returns the block to its idle state without touching the load and compare values.

Top module: `rdtimer`

## Requirements
- R1: A read accepted at a clock edge returns its data with `rsp_valid` high after that edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds and `req_ready` is low. Once the response is taken, a waiting request is accepted at that same edge.
- R2: The byte offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and count 0x10. After reset every register reads 0 and `irq` is low. Writes to the count offset are ignored, and any other offset reads 0.
- R3: Control bits 25:0 read back as written, with bit 16 excepted. The fields are: run bit 0, load-on-enable bit 1, interrupt enable bit 2, reload select bit 3, prescaler bits 15:4, soft reset bit 16, load-overwrite bit 17, four low-power enables at bits 21:18, output mode at bits 23:22 and clock select at bits 25:24. Bits 31:26 read 0.
- R4: With prescaler value P and the run bit set, the counter steps once every P+1 clocks. The first step comes P+1 clocks after the enabling write.
- R5: Each step lowers the count by one. A step taken at count 0 loads the load value when reload select is 1, and loads 0xFFFFFFFF when it is 0.
- R6: A control write that sets the run bit while the timer is stopped copies the load value into the counter, provided the same write sets load-on-enable.
- R7: While the run bit is 0 the count holds its value. Re-enabling with load-on-enable 0 resumes counting from the held count.
- R8: Status bit 0 is set when a step makes the count equal the compare value. It stays set until software writes 1 to status bit 0. Writing 0 there leaves it unchanged.
- R9: `irq` is high exactly when status bit 0 and control bit 2 are both 1.
- R10: While control bit 17 is 1, a write to the load register also copies the written value into the counter. While bit 17 is 0, the counter is unaffected.
- R11: A control write with bit 16 set clears the control fields, the match flag and the counter. A read in the next cycle shows control as 0x00010000, and bit 16 reads 0 again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 32-bit counter and 12-bit prescaler. At that width a wrap past zero shows up directly as 0xFFFFFFFF and 0xFFFFFFFE, and the compare value can be placed on the wrapped count. Load values stay small, so zero crossings, reloads and prescaler divisions up to four fall within a few dozen clocks. Random runs mix these settings, and directed cases reach soft reset, overwrite and back-pressure.

// File: rtl/rdtimer_pkg.sv
package rdtimer_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PRE_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;

  // control bit positions that the write path decodes directly
  localparam int B_RUN  = 0;
  localparam int B_LDON = 1;
  localparam int B_SRST = 16;
  localparam int B_FLAG = 0;

  typedef struct packed {
    logic [1:0]       clk_sel;
    logic [1:0]       out_mode;
    logic [3:0]       lp_en;
    logic             ovw;
    logic [PRE_W-1:0] presc;
    logic             reload;
    logic             irq_en;
    logic             load_on_en;
    logic             run;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic busy);
    return {6'b0, c.clk_sel, c.out_mode, c.lp_en, c.ovw, busy,
            c.presc, c.reload, c.irq_en, c.load_on_en, c.run};
  endfunction

  function automatic ctrl_t unpack_ctrl(input logic [25:0] w);
    ctrl_t c;
    c.run        = w[0];
    c.load_on_en = w[1];
    c.irq_en     = w[2];
    c.reload     = w[3];
    c.presc      = w[15:4];
    c.ovw        = w[17];
    c.lp_en      = w[21:18];
    c.out_mode   = w[23:22];
    c.clk_sel    = w[25:24];
    return c;
  endfunction

endpackage

// File: rtl/rdtimer_bus.sv
module rdtimer_bus #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en
);

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              accept;
  logic              rd_en;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;
  assign rd_en     = accept && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_en) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

endmodule

// File: rtl/rdtimer_presc.sv
module rdtimer_presc #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] phase_q;

  // phase restarts from zero whenever the timer is stopped
  assign tick = run && (phase_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!run)    phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + PRE_W'(1);
  end

endmodule

// File: rtl/rdtimer_count.sv
module rdtimer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ovw,
  input  logic [CNT_W-1:0] ovw_val,
  input  logic             en_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             tick,
  input  logic             reload,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             step;

  assign nxt  = (cnt_q == '0) ? (reload ? load_val : '1) : cnt_q - CNT_W'(1);
  assign step = tick && !clr && !ovw && !en_load;
  assign hit  = step && (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (ovw)     cnt_q <= ovw_val;
    else if (en_load) cnt_q <= load_val;
    else if (step)    cnt_q <= nxt;
  end

  assign count = cnt_q;

endmodule

// File: rtl/rdtimer_regs.sv
module rdtimer_regs
  import rdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              flag,
  output logic              srst_busy,
  output logic              cnt_clr,
  output logic              cnt_ovw,
  output logic              cnt_en_load,
  output logic [DATA_W-1:0] rd_data
);

  ctrl_t            ctrl_q;
  logic             srst_q;
  logic             flag_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cmp_q;
  logic             wr_ok;
  logic             w_ctrl, w_stat, w_load, w_cmp;
  logic             do_srst;
  logic             unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:26];

  // every write is dropped during the soft reset cycle
  assign wr_ok   = wr_en && !srst_q;
  assign w_ctrl  = wr_ok && (addr == OFS_CTRL);
  assign w_stat  = wr_ok && (addr == OFS_STAT);
  assign w_load  = wr_ok && (addr == OFS_LOAD);
  assign w_cmp   = wr_ok && (addr == OFS_CMP);
  assign do_srst = w_ctrl && wdata[B_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      srst_q <= 1'b0;
      flag_q <= 1'b0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      srst_q <= do_srst;
      if (w_ctrl) ctrl_q <= do_srst ? '0 : unpack_ctrl(wdata[25:0]);
      if (w_load) load_q <= wdata[CNT_W-1:0];
      if (w_cmp)  cmp_q  <= wdata[CNT_W-1:0];
      if (do_srst)                       flag_q <= 1'b0;
      else if (hit)                      flag_q <= 1'b1;
      else if (w_stat && wdata[B_FLAG])  flag_q <= 1'b0;
    end
  end

  assign cnt_clr     = do_srst;
  assign cnt_ovw     = w_load && ctrl_q.ovw;
  assign cnt_en_load = w_ctrl && !wdata[B_SRST] && wdata[B_RUN] && wdata[B_LDON] && !ctrl_q.run;

  always_comb begin
    case (addr)
      OFS_CTRL: rd_data = pack_ctrl(ctrl_q, srst_q);
      OFS_STAT: rd_data = {{(DATA_W-1){1'b0}}, flag_q};
      OFS_LOAD: rd_data = DATA_W'(load_q);
      OFS_CMP:  rd_data = DATA_W'(cmp_q);
      OFS_CNT:  rd_data = DATA_W'(count);
      default:  rd_data = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign load_val  = load_q;
  assign cmp_val   = cmp_q;
  assign flag      = flag_q;
  assign srst_busy = srst_q;

endmodule

// File: rtl/rdtimer.sv
module rdtimer
  import rdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);

  ctrl_t             ctrl_q;
  logic              wr_en;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  load_val, cmp_val, count;
  logic              flag, srst_busy, cnt_clr, cnt_ovw, cnt_en_load;
  logic              tick, hit;
  logic              ctl_run, ctl_ie;

  assign ctl_run = ctrl_q.run;
  assign ctl_ie  = ctrl_q.irq_en;

  rdtimer_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rd_data(rd_data), .wr_en(wr_en)
  );

  rdtimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(req_addr), .wdata(req_wdata),
    .hit(hit), .count(count), .ctrl(ctrl_q), .load_val(load_val), .cmp_val(cmp_val),
    .flag(flag), .srst_busy(srst_busy), .cnt_clr(cnt_clr), .cnt_ovw(cnt_ovw),
    .cnt_en_load(cnt_en_load), .rd_data(rd_data)
  );

  rdtimer_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctl_run), .div(ctrl_q.presc), .tick(tick)
  );

  rdtimer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .ovw(cnt_ovw), .ovw_val(req_wdata[CNT_W-1:0]),
    .en_load(cnt_en_load), .load_val(load_val), .cmp_val(cmp_val), .tick(tick),
    .reload(ctrl_q.reload), .count(count), .hit(hit)
  );

  assign irq = flag && ctl_ie;

endmodule

// File: rtl/rdtimer_checker.sv
module rdtimer_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             irq,
  input logic             run,
  input logic             irq_en,
  input logic             flag,
  input logic             srst_busy,
  input logic [CNT_W-1:0] count
);

  logic wr_acc;
  assign wr_acc = req_valid && req_ready && req_write;

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wr_acc && count != '0 |=> (count == $past(count)) || (count == $past(count) - CNT_W'(1)));

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_acc |=> $stable(count));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr_acc |=> flag);

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    flag && irq_en && !wr_acc |=> irq);

  a_r11_srst_release: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> !srst_busy);

endmodule

bind rdtimer rdtimer_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq(irq), .run(ctl_run), .irq_en(ctl_ie),
  .flag(flag), .srst_busy(srst_busy), .count(count)
);

// File: tb/test_rdtimer.sv
`timescale 1ns/1ps
module test_rdtimer;
  import rdtimer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int unsigned cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rdtimer i_rdtimer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge; e is the index of the edge that took the request
  task automatic wr_e(input logic [4:0] a, input logic [31:0] d, output int unsigned e);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    e = cyc;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    int unsigned e;
    wr_e(a, d, e);
  endtask

  task automatic rd_e(input logic [4:0] a, output logic [31:0] d, output int unsigned e);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    e = cyc;
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    int unsigned e;
    rd_e(a, d, e);
  endtask

  // count and match flag after n candidate edges following the enabling write
  function automatic void model(input logic [31:0] ld, input int p, input bit rl, input logic [31:0] c,
                                input int unsigned n, output logic [31:0] v, output bit h);
    v = ld; h = 1'b0;
    for (int unsigned k = 0; k < n / (p + 1); k++) begin
      v = (v == 32'd0) ? (rl ? ld : 32'hFFFF_FFFF) : v - 32'd1;
      if (v == c) h = 1'b1;
    end
  endfunction

  task automatic run_case(input logic [31:0] ld, input int p, input bit rl, input logic [31:0] c,
                          input int w, input string tag);
    int unsigned e, r;
    logic [31:0] d, ev;
    bit eh;
    wr(OFS_CTRL, 32'd0);
    wr(OFS_STAT, 32'd1);
    wr(OFS_LOAD, ld);
    wr(OFS_CMP, c);
    wr_e(OFS_CTRL, (32'(p) << 4) | (rl ? 32'd8 : 32'd0) | 32'd7, e);
    repeat (w) @(negedge clk);
    rd_e(OFS_CNT, d, r);
    model(ld, p, rl, c, r - e - 1, ev, eh);
    check(tag, d, ev, "count");
    rd_e(OFS_STAT, d, r);
    model(ld, p, rl, c, r - e - 1, ev, eh);
    check("R8", d, {31'b0, eh}, "match flag");
    model(ld, p, rl, c, cyc - e, ev, eh);
    check("R9", {31'b0, irq}, {31'b0, eh}, "irq level");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, h;
    int unsigned e, e2, r;
    void'($urandom(32'd6151));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(OFS_CTRL, d); check("R2", d, 32'd0, "ctrl after reset");
    rd(OFS_STAT, d); check("R2", d, 32'd0, "status after reset");
    rd(OFS_LOAD, d); check("R2", d, 32'd0, "load after reset");
    rd(OFS_CNT, d);  check("R2", d, 32'd0, "count after reset");
    check("R2", {31'b0, irq}, 32'd0, "irq after reset");

    // R3 stored configuration bits
    wr(OFS_CTRL, 32'hFFFE_FFF0);
    rd(OFS_CTRL, d); check("R3", d, 32'h03FE_FFF0, "ctrl readback");
    wr(OFS_CTRL, 32'd0);

    // R6 load on enable, R4 prescaler, R5 rollover and reload
    run_case(32'd37, 0, 1'b1, 32'd99, 0, "R6");
    run_case(32'd20, 2, 1'b0, 32'd15, 17, "R4");
    run_case(32'd2, 0, 1'b0, 32'hFFFF_FFFE, 4, "R5");
    run_case(32'd3, 0, 1'b1, 32'd7, 5, "R5");

    // R7 hold while stopped, resume without reload
    wr(OFS_CTRL, 32'd0);
    wr(OFS_LOAD, 32'd100);
    wr_e(OFS_CTRL, 32'd3, e);
    repeat (5) @(negedge clk);
    wr_e(OFS_CTRL, 32'd0, e2);
    h = 32'd100 - (e2 - e);
    rd(OFS_CNT, d); check("R7", d, h, "count after stop");
    repeat (10) @(negedge clk);
    rd(OFS_CNT, d); check("R7", d, h, "count held while stopped");
    wr_e(OFS_CTRL, 32'd1, e);
    repeat (3) @(negedge clk);
    rd_e(OFS_CNT, d, r); check("R7", d, h - (r - e - 1), "count resumed");

    // R8 / R9 flag clearing and gating
    run_case(32'd1, 0, 1'b0, 32'd0, 3, "R5");
    wr(OFS_CTRL, 32'd4);
    check("R9", {31'b0, irq}, 32'd1, "irq with flag and enable");
    wr(OFS_STAT, 32'd0);
    rd(OFS_STAT, d); check("R8", d, 32'd1, "write 0 keeps flag");
    wr(OFS_CTRL, 32'd0);
    check("R9", {31'b0, irq}, 32'd0, "irq gated off");
    wr(OFS_CTRL, 32'd4);
    check("R9", {31'b0, irq}, 32'd1, "irq gated on");
    wr(OFS_STAT, 32'd1);
    rd(OFS_STAT, d); check("R8", d, 32'd0, "write 1 clears flag");
    check("R9", {31'b0, irq}, 32'd0, "irq after clear");

    // R10 overwrite; R2 count offset write ignored, unmapped offset
    wr(OFS_CTRL, 32'h0002_0000);
    wr(OFS_LOAD, 32'h1234);
    rd(OFS_CNT, d); check("R10", d, 32'h1234, "overwrite copies load");
    wr(OFS_CTRL, 32'd0);
    wr(OFS_LOAD, 32'h55);
    rd(OFS_CNT, d); check("R10", d, 32'h1234, "no copy without overwrite");
    rd(OFS_LOAD, d); check("R10", d, 32'h55, "load value stored");
    wr(OFS_CNT, 32'hDEAD);
    rd(OFS_CNT, d); check("R2", d, 32'h1234, "count write ignored");
    rd(5'h14, d); check("R2", d, 32'd0, "unmapped read");

    // R11 soft reset
    run_case(32'd1, 0, 1'b0, 32'd0, 3, "R5");
    wr(OFS_CTRL, 32'd0);
    wr(OFS_CTRL, 32'h0300_0025);
    wr(OFS_CTRL, 32'h0001_0000);
    rd(OFS_CTRL, d); check("R11", d, 32'h0001_0000, "reset bit visible");
    rd(OFS_CTRL, d); check("R11", d, 32'd0, "reset bit released");
    rd(OFS_CNT, d);  check("R11", d, 32'd0, "count cleared");
    rd(OFS_STAT, d); check("R11", d, 32'd0, "flag cleared");
    check("R11", {31'b0, irq}, 32'd0, "irq after soft reset");

    // R1 back-pressure
    wr(OFS_LOAD, 32'hAA);
    wr(OFS_CMP, 32'hBB);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = OFS_LOAD;
    @(negedge clk);
    req_addr = OFS_CMP;
    check("R1", {31'b0, rsp_valid}, 32'd1, "response valid");
    check("R1", {31'b0, req_ready}, 32'd0, "ready low while stalled");
    repeat (2) @(negedge clk);
    check("R1", rsp_rdata, 32'hAA, "data held under stall");
    check("R1", {31'b0, req_ready}, 32'd0, "ready still low");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    d2 = rsp_rdata;
    check("R1", d2, 32'hBB, "waiting read taken on release");
    @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'd0, "response drained");

    // random runs
    for (int i = 0; i < 30; i++) begin
      run_case($urandom_range(0, 30), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               $urandom_range(0, 30), $urandom_range(0, 40), "R5");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule